// File: doc/BRIEF.md
# Descriptor Queue Manager

This block holds a large set of hardware FIFO queues of descriptor pointers behind one register interface. A producer, either software or a DMA engine, queues a descriptor by writing its 32-byte-aligned address to a queue's push/pop register. The low five bits of that write carry a size code. A consumer reads the same register to remove the oldest entry of that queue, and gets zero when the queue is empty. All queues are linked lists that share one internal link store. The link store is indexed by descriptor number, which is derived from the address and a programmable descriptor region.

Packed status words show which queues hold entries. One interrupt line watches the upper range of queues, which serve as completion queues. Writes and reads arrive on separate strobes, so a push and a pop can land in the same cycle. When they target the same queue, the push is applied first.

Top module: `hw_desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty, every status word reads 0, `irq` is low, the region base reads 0 and the region control reads 0x0000_0002.
- R2: A write to byte address 0x2000 + 16·n + 0xC pushes onto queue n. A read of the same address pops queue n, and the popped word appears on `rd_data` one clock after the read strobe.
- R3: Each queue returns its entries strictly first in, first out, and traffic on one queue does not disturb the contents of another.
- R4: A pop of an empty queue returns 0 and leaves every queue unchanged.
- R5: The status word at byte address 0x90 + 4·i has bit b set exactly when queue 32·i + b holds at least one entry. It changes on the clock edge that performs the push or pop.
- R6: `irq` is high exactly when some queue numbered 93 or above is non-empty. Entries in queues 0 to 92 never raise it.
- R7: A push is accepted only when all three of these hold: the aligned address is at or above the base at 0x1000; the offset (address − base)/32 is below 2^(c+5), where c is bits 4:0 of the control word at 0x1004; and the start index (control bits 31:16) plus the offset is below 128. Any other push is dropped, the queue is left untouched, and `wr_drop` pulses high for one cycle on the following clock.
- R8: When a push and a pop hit the same queue in one cycle, the push is applied first. On an empty queue the pop returns the pushed descriptor and the queue stays empty. On a non-empty queue the pop returns the old head and the pushed entry joins the tail.
- R9: The size code in bits 4:0 of a push is stored with the descriptor and returned in bits 4:0 of the popped word. The upper bits of the popped word equal base + 32 × (index − start).
- R10: The region base at 0x1000 and the region control at 0x1004 read back the last value written.
- R11: All 128 descriptors can be queued at once, spread across several queues, and each one is returned in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 14 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of a queue register pops it |
| rd_addr | input | 14 | Read byte address |
| rd_data | output | 32 | Read data, valid one clock after `rd_en` |
| irq | output | 1 | Completion interrupt: some queue at or above 93 is non-empty |
| wr_drop | output | 1 | One-cycle pulse: the last push fell outside the descriptor region |

## Verification
On every cycle the assertions check these properties:
- a drop pulse always follows a write;
- a pop that finds nothing returns zero;
- the number of non-empty queues grows by at most one per cycle, and only after a write;
- the interrupt never rises without some pending status.

Only the bench scenarios can show the rest:
- FIFO order and independence of the queues;
- the address arithmetic of the region check and the returned words;
- the merged push-and-pop cases;
- a completely filled pool.

These are checked against a per-queue reference model under random traffic and directed corners.

// File: rtl/hw_desc_queue_mgr.sv
module hw_desc_queue_mgr #(
  parameter int NUM_Q      = 160,
  parameter int POOL       = 128,
  parameter int DESC_BYTES = 32,
  parameter int COMP_FIRST = 93,
  parameter int AW         = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq,
  output logic          wr_drop
);
  localparam int QW  = $clog2(NUM_Q);
  localparam int IW  = $clog2(POOL);
  localparam int CW  = $clog2(POOL + 1);
  localparam int PW  = (NUM_Q + 31) / 32;
  localparam int DSH = $clog2(DESC_BYTES);
  localparam logic [AW-5:0] SLOT0  = (AW-4)'('h200);
  localparam logic [AW-1:0] A_BASE = AW'('h1000);
  localparam logic [AW-1:0] A_CTRL = AW'('h1004);
  localparam logic [AW-1:0] A_PEND = AW'('h90);

  logic [31:0]      base_r, ctrl_r;
  logic [PW*32-1:0] pend;
  logic [CW-1:0]    cnt_q  [NUM_Q];
  logic [IW-1:0]    head_q [NUM_Q];
  logic [IW-1:0]    tail_q [NUM_Q];
  logic [IW-1:0]    nxt_r  [POOL];
  logic [4:0]       szc_r  [POOL];

  logic [AW-5:0] wslot, wrel, rslot, rrel;
  logic          wr_is_q, rd_is_q;
  logic [QW-1:0] wq, pq;

  assign wslot   = wr_addr[AW-1:4];
  assign wrel    = wslot - SLOT0;
  assign wr_is_q = (wr_addr[3:0] == 4'hC) && (wslot >= SLOT0) && (wrel < (AW-4)'(NUM_Q));
  assign wq      = wrel[QW-1:0];
  assign rslot   = rd_addr[AW-1:4];
  assign rrel    = rslot - SLOT0;
  assign rd_is_q = (rd_addr[3:0] == 4'hC) && (rslot >= SLOT0) && (rrel < (AW-4)'(NUM_Q));
  assign pq      = rrel[QW-1:0];

  logic [31:0] w_addr, w_off, idx_full;
  logic [63:0] span;
  logic        in_reg, push_ok, push_bad;
  logic [IW-1:0] pidx;

  assign w_addr   = {wr_data[31:DSH], {DSH{1'b0}}};
  assign w_off    = (w_addr - base_r) >> DSH;
  assign span     = {32'd0, w_off} >> (6'(ctrl_r[4:0]) + 6'd5);
  assign idx_full = 32'(ctrl_r[31:16]) + w_off;
  assign in_reg   = (w_addr >= base_r) && (span == 64'd0) && (idx_full < 32'(POOL));
  assign push_ok  = wr_en && wr_is_q && in_reg;
  assign push_bad = wr_en && wr_is_q && !in_reg;
  assign pidx     = idx_full[IW-1:0];

  logic          pop_go, pop_take, pop_any, same;
  logic [CW-1:0] pc;
  logic [IW-1:0] ph, pop_idx;
  logic [4:0]    pop_sz;
  logic [31:0]   rel, pop_val, rd_next;

  assign pop_go   = rd_en && rd_is_q;
  assign same     = push_ok && pop_go && (wq == pq);
  assign pc       = cnt_q[pq];
  assign ph       = head_q[pq];
  assign pop_take = pop_go && (pc != '0);
  assign pop_any  = (pc != '0) || same;
  assign pop_idx  = (pc != '0) ? ph : pidx;
  assign pop_sz   = (pc != '0) ? szc_r[ph] : wr_data[4:0];
  assign rel      = 32'(pop_idx) - 32'(ctrl_r[31:16]);
  assign pop_val  = pop_any ? ((base_r + (rel << DSH)) | {27'd0, pop_sz}) : 32'd0;

  always_comb begin
    rd_next = 32'd0;
    if (rd_addr == A_BASE) rd_next = base_r;
    if (rd_addr == A_CTRL) rd_next = ctrl_r;
    for (int i = 0; i < PW; i++)
      if (rd_addr == A_PEND + AW'(4 * i)) rd_next = pend[32*i +: 32];
    if (rd_is_q) rd_next = pop_val;
  end

  assign irq = |(pend >> COMP_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r  <= 32'd0;
      ctrl_r  <= 32'd2;
      pend    <= '0;
      rd_data <= 32'd0;
      wr_drop <= 1'b0;
      for (int q = 0; q < NUM_Q; q++) cnt_q[q] <= '0;
    end else begin
      wr_drop <= push_bad;
      if (rd_en) rd_data <= rd_next;
      if (wr_en && wr_addr == A_BASE) base_r <= wr_data;
      if (wr_en && wr_addr == A_CTRL) ctrl_r <= wr_data;
      if (push_ok && !same) begin
        cnt_q[wq] <= cnt_q[wq] + CW'(1);
        pend[wq]  <= 1'b1;
      end
      if (pop_take && !same) begin
        cnt_q[pq] <= pc - CW'(1);
        pend[pq]  <= (pc != CW'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !(same && pc == '0)) begin
      szc_r[pidx] <= wr_data[4:0];
      if (cnt_q[wq] != '0) nxt_r[tail_q[wq]] <= pidx;
      else                 head_q[wq] <= pidx;
      tail_q[wq] <= pidx;
    end
    if (pop_take)
      head_q[pq] <= (same && pc == CW'(1)) ? pidx : nxt_r[ph];
  end
endmodule

// File: rtl/qm_chk.sv
module qm_chk #(
  parameter int PW         = 5,
  parameter int COMP_FIRST = 93
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq,
  input logic             wr_drop,
  input logic [PW*32-1:0] pend,
  input logic             pop_go,
  input logic             pop_take,
  input logic             same,
  input logic [31:0]      rd_data
);
  // R7
  drop_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> $past(wr_en));

  // R4
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && !pop_take && !same) |=> (rd_data == 32'd0));

  // R5
  pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend) <= $past($countones(pend)) + 1);

  // R5
  pend_grow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend) > $past($countones(pend))) |-> $past(wr_en));

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

  // R6
  irq_first_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[COMP_FIRST] |-> irq);
endmodule

bind hw_desc_queue_mgr qm_chk #(.PW(PW), .COMP_FIRST(COMP_FIRST)) u_qm_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq), .wr_drop(wr_drop),
  .pend(pend), .pop_go(pop_go), .pop_take(pop_take), .same(same),
  .rd_data(rd_data)
);

// File: tb/tb_hw_desc_queue_mgr.sv
`timescale 1ns/1ps
module tb_hw_desc_queue_mgr;
  localparam int NQ = 160;
  localparam int NP = 128;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [13:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, wr_drop;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mq [NQ][$];
  bit          used [NP];

  always #2.5 clk = ~clk;

  hw_desc_queue_mgr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wr_drop(wr_drop)
  );

  function automatic logic [13:0] qaddr(int q);
    return 14'(32'h2000 + 16 * q + 12);
  endfunction

  function automatic logic [31:0] dsc(int idx, int code);
    return BASE + 32'(idx * 32) + 32'(code & 31);
  endfunction

  function automatic logic [31:0] exp_pend(int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (32 * w + b < NQ && mq[32 * w + b].size() != 0) v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic exp_irq();
    for (int q = 93; q < NQ; q++) if (mq[q].size() != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d, output logic drop);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    drop = wr_drop;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic both(input int qw, input logic [31:0] d, input int qr, output logic [31:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = qaddr(qw); wr_data = d;
    rd_en = 1'b1; rd_addr = qaddr(qr);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    r = rd_data;
  endtask

  task automatic check_status(input string req);
    logic [31:0] v;
    for (int w = 0; w < 5; w++) begin
      rd(14'(32'h90 + 4 * w), v);
      chk(v == exp_pend(w), req, v, exp_pend(w));
    end
    chk(irq == exp_irq(), "R6", 32'(irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        dr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_status("R1");
    rd(14'h1000, v); chk(v == 32'd0, "R1", v, 32'd0);
    rd(14'h1004, v); chk(v == 32'd2, "R1", v, 32'd2);

    // R10 region readback
    wr(14'h1000, BASE, dr);
    rd(14'h1000, v); chk(v == BASE, "R10", v, BASE);

    // R4 empty pop
    rd(qaddr(7), v); chk(v == 32'd0, "R4", v, 32'd0);

    // R2 R3 R9 ordered pops with size codes
    wr(qaddr(10), dsc(3, 2), dr);
    wr(qaddr(10), dsc(9, 17), dr);
    wr(qaddr(11), dsc(40, 31), dr);
    wr(qaddr(10), dsc(0, 0), dr);
    rd(14'h90, v); chk(v == 32'h0000_0C00, "R5", v, 32'h0000_0C00);
    rd(qaddr(10), v); chk(v == dsc(3, 2), "R2", v, dsc(3, 2));
    rd(qaddr(10), v); chk(v == dsc(9, 17), "R9", v, dsc(9, 17));
    rd(qaddr(11), v); chk(v == dsc(40, 31), "R3", v, dsc(40, 31));
    rd(qaddr(10), v); chk(v == dsc(0, 0), "R3", v, dsc(0, 0));
    rd(qaddr(10), v); chk(v == 32'd0, "R4", v, 32'd0);
    rd(14'h90, v); chk(v == 32'd0, "R5", v, 32'd0);

    // R6 interrupt boundary at queue 93
    wr(qaddr(92), dsc(5, 2), dr);
    chk(irq == 1'b0, "R6", 32'(irq), 32'd0);
    rd(14'h98, v); chk(v == 32'h1000_0000, "R5", v, 32'h1000_0000);
    wr(qaddr(93), dsc(6, 2), dr);
    chk(irq == 1'b1, "R6", 32'(irq), 32'd1);
    rd(qaddr(93), v); chk(v == dsc(6, 2), "R2", v, dsc(6, 2));
    chk(irq == 1'b0, "R6", 32'(irq), 32'd0);
    rd(qaddr(92), v); chk(v == dsc(5, 2), "R2", v, dsc(5, 2));

    // R7 region checks and drops
    wr(qaddr(4), BASE - 32'd32, dr);
    chk(dr == 1'b1, "R7", 32'(dr), 32'd1);
    wr(qaddr(4), dsc(128, 2), dr);
    chk(dr == 1'b1, "R7", 32'(dr), 32'd1);
    wr(qaddr(4), dsc(127, 2), dr);
    chk(dr == 1'b0, "R7", 32'(dr), 32'd0);
    rd(qaddr(4), v); chk(v == dsc(127, 2), "R7", v, dsc(127, 2));
    rd(qaddr(4), v); chk(v == 32'd0, "R7", v, 32'd0);
    wr(14'h1004, 32'h0064_0000, dr);
    wr(qaddr(4), dsc(27, 3), dr);
    chk(dr == 1'b0, "R7", 32'(dr), 32'd0);
    wr(qaddr(4), dsc(28, 3), dr);
    chk(dr == 1'b1, "R7", 32'(dr), 32'd1);
    rd(qaddr(4), v); chk(v == dsc(27, 3), "R9", v, dsc(27, 3));
    rd(qaddr(4), v); chk(v == 32'd0, "R7", v, 32'd0);
    wr(14'h1004, 32'h0000_0000, dr);
    wr(qaddr(4), dsc(32, 2), dr);
    chk(dr == 1'b1, "R7", 32'(dr), 32'd1);
    rd(qaddr(4), v); chk(v == 32'd0, "R7", v, 32'd0);
    wr(14'h1004, 32'h0000_0002, dr);

    // R8 same-cycle push and pop
    both(20, dsc(11, 2), 20, v); chk(v == dsc(11, 2), "R8", v, dsc(11, 2));
    rd(qaddr(20), v); chk(v == 32'd0, "R8", v, 32'd0);
    wr(qaddr(21), dsc(12, 2), dr);
    both(21, dsc(13, 5), 21, v); chk(v == dsc(12, 2), "R8", v, dsc(12, 2));
    rd(qaddr(21), v); chk(v == dsc(13, 5), "R8", v, dsc(13, 5));
    rd(qaddr(21), v); chk(v == 32'd0, "R8", v, 32'd0);

    // R11 full pool
    for (int i = 0; i < NP; i++) begin
      wr(qaddr(140 + i % 5), dsc(i, i), dr);
      mq[140 + i % 5].push_back(dsc(i, i));
    end
    check_status("R11");
    for (int q = 140; q < 145; q++)
      while (mq[q].size() != 0) begin
        logic [31:0] e;
        e = mq[q].pop_front();
        rd(qaddr(q), v); chk(v == e, "R11", v, e);
      end

    // R3 R5 R6 random traffic against the model
    begin
      int qs [8] = '{0, 5, 31, 32, 92, 93, 120, 159};
      void'($urandom(32'h1234_5678));
      for (int n = 0; n < 3000; n++) begin
        int q, start, idx;
        q = qs[$urandom_range(7)];
        if ($urandom_range(99) < 55) begin
          start = $urandom_range(NP - 1);
          idx = -1;
          for (int k = 0; k < NP; k++)
            if (idx < 0 && !used[(start + k) % NP]) idx = (start + k) % NP;
          if (idx >= 0) begin
            logic [31:0] d;
            d = dsc(idx, $urandom_range(31));
            used[idx] = 1'b1;
            wr(qaddr(q), d, dr);
            mq[q].push_back(d);
          end
        end else begin
          logic [31:0] e;
          e = (mq[q].size() != 0) ? mq[q].pop_front() : 32'd0;
          rd(qaddr(q), v);
          chk(v == e, "R3", v, e);
          if (e != 32'd0) used[(e - BASE) >> 5] = 1'b0;
        end
        if (n % 250 == 0) check_status("R5");
      end
    end
    check_status("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule